// File: doc/BRIEF.md
# Dual-View Superframe Window Splitter

A superframe carries two video views placed side by side on every line. This block watches one such pixel stream and cuts it into two windows, one per view. Each window has its own skip count, inclusive last-pixel index and inclusive last-line index. Every window forwards only the pixels that fall inside its rectangle. It marks the first and the last pixel it emits on each line.

Both windows sit on one shared position tracker, so they always agree on where a pixel lies. Each window carries a pairing group number. If the two group numbers differ, the pair is refused and neither window emits anything. Software writes the settings one byte at a time into a staging copy. The staging copy moves into use only on the first pixel of the next frame. As a result, no frame is ever cropped with a mix of old and new settings.

Top module: `dual_view_split`

## Requirements
- R1: After reset every output is low, including `pair_reject`. The reset value of all staged and active settings is zero, so no pixel is accepted until the block is configured.
- R2: Pixels are numbered from 1 within each line. A valid pixel with `pix_sol` or `pix_sof` set is column 1, and each later valid pixel adds one. Columns 1 up to the skip count are never emitted.
- R3: A pixel is emitted by a window only when its column is greater than the skip count and at most the last-pixel index. The last-pixel index is normally programmed as skip plus view width.
- R4: Lines are numbered from 1. The valid pixel with `pix_sof` starts line 1, and each later valid `pix_sol` adds one. Lines numbered above the last-line index, and any line seen before the first `pix_sof`, are dropped.
- R5: `viewN_sol` is high exactly on the emitted pixel at column skip+1.
- R6: `viewN_eol` is high exactly on the emitted pixel whose column equals the last-pixel index.
- R7: An emitted pixel appears one clock after it was presented, with its data unchanged. Cycles with `pix_valid` low neither advance the position nor load settings, whatever `pix_sol`, `pix_sof` and `pix_data` carry.
- R8: A configuration write with `cfg_wr` high goes to the staging copy. `cfg_addr[3]` selects the view (0 or 1), and `cfg_addr[2:0]` selects the byte: 0/1 = skip low/high, 2/3 = last-pixel low/high, 4/5 = last-line low/high, 6 = group. Staged values take effect starting with the valid `pix_sof` pixel that follows the write, and that pixel is itself judged with them.
- R9: While the active group numbers of the two views differ, `pair_reject` is high and neither view emits a pixel.
- R10: With skips 0 and 1920, last-pixel indices 1920 and 3840 and equal groups, every pixel of a 3840-wide line inside the line window is emitted by exactly one view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Bit 3 selects the view; bits 2:0 select the byte |
| cfg_wdata | input | 8 | Configuration byte |
| pix_valid | input | 1 | Input pixel present |
| pix_sol | input | 1 | Input pixel is the first pixel of a line |
| pix_sof | input | 1 | Input pixel is the first pixel of a frame |
| pix_data | input | DATA_W | Input pixel value |
| view0_valid | output | 1 | View 0 pixel present |
| view0_sol | output | 1 | View 0 first pixel of line |
| view0_eol | output | 1 | View 0 last pixel of line |
| view0_data | output | DATA_W | View 0 pixel value |
| view1_valid | output | 1 | View 1 pixel present |
| view1_sol | output | 1 | View 1 first pixel of line |
| view1_eol | output | 1 | View 1 last pixel of line |
| view1_data | output | DATA_W | View 1 pixel value |
| pair_reject | output | 1 | Active group numbers disagree; both views silent |

## Verification
The delicate coincidence is a configuration write landing in the same cycle as a stream pixel. In one case the write lands mid-frame next to an ordinary pixel. In the other, a later start-of-frame pixel must switch to the staged values while the active ones still govern the rest of the earlier frame. The bench issues a skip write together with a pixel in the middle of a frame. A cycle-accurate reference model then judges every output of that frame and of the next, and per-frame pixel counts confirm the old width before the switch and the new width after it. A second coincidence, the first emitted pixel also being the last on a line, does not arise in the chosen widths.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

  localparam int COORD_W = 16;
  localparam int GROUP_W = 8;
  localparam int NUM_VIEWS = 2;

  typedef struct packed {
    logic [COORD_W-1:0] skip;
    logic [COORD_W-1:0] last_px;
    logic [COORD_W-1:0] last_ln;
    logic [GROUP_W-1:0] group;
  } win_cfg_t;

  typedef enum logic [2:0] {
    FLD_SKIP_LO  = 3'd0,
    FLD_SKIP_HI  = 3'd1,
    FLD_LASTPX_LO = 3'd2,
    FLD_LASTPX_HI = 3'd3,
    FLD_LASTLN_LO = 3'd4,
    FLD_LASTLN_HI = 3'd5,
    FLD_GROUP    = 3'd6,
    FLD_NONE     = 3'd7
  } cfg_field_e;

endpackage

// File: rtl/dvs_cfg_bank.sv
module dvs_cfg_bank
  import dvs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [2:0] field_i,
  input  logic [7:0] wdata_i,
  input  logic       load_i,
  output win_cfg_t   eff_o,
  output win_cfg_t   act_o
);

  win_cfg_t stage_q, stage_d;
  win_cfg_t act_q, act_d;

  always_comb begin
    stage_d = stage_q;
    if (wr_en_i) begin
      case (cfg_field_e'(field_i))
        FLD_SKIP_LO:   stage_d.skip[7:0]     = wdata_i;
        FLD_SKIP_HI:   stage_d.skip[15:8]    = wdata_i;
        FLD_LASTPX_LO: stage_d.last_px[7:0]  = wdata_i;
        FLD_LASTPX_HI: stage_d.last_px[15:8] = wdata_i;
        FLD_LASTLN_LO: stage_d.last_ln[7:0]  = wdata_i;
        FLD_LASTLN_HI: stage_d.last_ln[15:8] = wdata_i;
        FLD_GROUP:     stage_d.group         = wdata_i;
        default:       stage_d = stage_q;
      endcase
    end
  end

  always_comb begin
    act_d = act_q;
    if (load_i) act_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  // The frame-start pixel is judged with the staged values.
  assign eff_o = act_d;
  assign act_o = act_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_q)); // R8

endmodule

// File: rtl/dvs_pos_track.sv
module dvs_pos_track
  import dvs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               sol_i,
  input  logic               sof_i,
  output logic [COORD_W-1:0] col_o,
  output logic [COORD_W-1:0] line_o
);

  logic [COORD_W-1:0] col_q, col_d;
  logic [COORD_W-1:0] line_q, line_d;

  always_comb begin
    if (sof_i || sol_i) col_d = COORD_W'(1);
    else                col_d = col_q + COORD_W'(1);
    if (sof_i)          line_d = COORD_W'(1);
    else if (sol_i)     line_d = line_q + COORD_W'(1);
    else                line_d = line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      line_q <= '0;
    end else if (valid_i) begin
      col_q  <= col_d;
      line_q <= line_d;
    end
  end

  assign col_o  = col_d;
  assign line_o = line_d;

  AST_COL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (sol_i || sof_i)) |=> (col_q == COORD_W'(1))); // R2
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sof_i) |=> (line_q == COORD_W'(1))); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(col_q) && $stable(line_q))); // R7

endmodule

// File: rtl/dvs_window.sv
module dvs_window
  import dvs_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  win_cfg_t           cfg_i,
  input  logic               enable_i,
  input  logic               valid_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic [COORD_W-1:0] line_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               valid_o,
  output logic               sol_o,
  output logic               eol_o,
  output logic [DATA_W-1:0]  data_o
);

  localparam int WIDE_W = COORD_W + 1;

  logic in_cols, in_lines, accept, first_px, last_px;
  logic valid_q, sol_q, eol_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    in_cols  = (col_i > cfg_i.skip) && (col_i <= cfg_i.last_px);
    in_lines = (line_i != '0) && (line_i <= cfg_i.last_ln);
    accept   = valid_i && enable_i && in_cols && in_lines;
    first_px = ({1'b0, col_i} == ({1'b0, cfg_i.skip} + WIDE_W'(1)));
    last_px  = (col_i == cfg_i.last_px);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sol_q   <= 1'b0;
      eol_q   <= 1'b0;
    end else begin
      valid_q <= accept;
      sol_q   <= accept && first_px;
      eol_q   <= accept && last_px;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (valid_i) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign sol_o   = sol_q;
  assign eol_o   = eol_q;
  assign data_o  = data_q;

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(valid_i)); // R7
  AST_MARK_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sol_q || eol_q) |-> $past(enable_i)); // R5

endmodule

// File: rtl/dual_view_split.sv
module dual_view_split
  import dvs_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              pix_valid,
  input  logic              pix_sol,
  input  logic              pix_sof,
  input  logic [DATA_W-1:0] pix_data,
  output logic              view0_valid,
  output logic              view0_sol,
  output logic              view0_eol,
  output logic [DATA_W-1:0] view0_data,
  output logic              view1_valid,
  output logic              view1_sol,
  output logic              view1_eol,
  output logic [DATA_W-1:0] view1_data,
  output logic              pair_reject
);

  logic               frame_load;
  logic [COORD_W-1:0] cur_col, cur_line;
  win_cfg_t           eff_cfg [NUM_VIEWS];
  win_cfg_t           act_cfg [NUM_VIEWS];
  logic               pair_ok;
  logic [NUM_VIEWS-1:0] v_valid, v_sol, v_eol;
  logic [DATA_W-1:0]  v_data [NUM_VIEWS];

  assign frame_load = pix_valid && pix_sof;

  dvs_pos_track u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (pix_valid),
    .sol_i   (pix_sol),
    .sof_i   (pix_sof),
    .col_o   (cur_col),
    .line_o  (cur_line)
  );

  assign pair_ok = (eff_cfg[0].group == eff_cfg[1].group);

  for (genvar k = 0; k < NUM_VIEWS; k++) begin : g_view
    logic wr_sel;
    assign wr_sel = cfg_wr && (cfg_addr[3] == 1'(k));

    dvs_cfg_bank u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_sel),
      .field_i (cfg_addr[2:0]),
      .wdata_i (cfg_wdata),
      .load_i  (frame_load),
      .eff_o   (eff_cfg[k]),
      .act_o   (act_cfg[k])
    );

    dvs_window #(.DATA_W(DATA_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (eff_cfg[k]),
      .enable_i (pair_ok),
      .valid_i  (pix_valid),
      .col_i    (cur_col),
      .line_i   (cur_line),
      .data_i   (pix_data),
      .valid_o  (v_valid[k]),
      .sol_o    (v_sol[k]),
      .eol_o    (v_eol[k]),
      .data_o   (v_data[k])
    );
  end

  assign pair_reject = (act_cfg[0].group != act_cfg[1].group);

  assign view0_valid = v_valid[0];
  assign view0_sol   = v_sol[0];
  assign view0_eol   = v_eol[0];
  assign view0_data  = v_data[0];
  assign view1_valid = v_valid[1];
  assign view1_sol   = v_sol[1];
  assign view1_eol   = v_eol[1];
  assign view1_data  = v_data[1];

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pair_reject |-> (v_valid == '0)); // R9

endmodule

// File: tb/dual_view_split_bench.sv
`timescale 1ns/1ps
module dual_view_split_bench;

  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic pix_valid = 1'b0, pix_sol = 1'b0, pix_sof = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic v0_valid, v0_sol, v0_eol, v1_valid, v1_sol, v1_eol, pair_reject;
  logic [DW-1:0] v0_data, v1_data;

  always #2 clk = ~clk;

  dual_view_split #(.DATA_W(DW)) u_dual_view_split (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_sol(pix_sol),
    .pix_sof(pix_sof), .pix_data(pix_data),
    .view0_valid(v0_valid), .view0_sol(v0_sol), .view0_eol(v0_eol), .view0_data(v0_data),
    .view1_valid(v1_valid), .view1_sol(v1_sol), .view1_eol(v1_eol), .view1_data(v1_data),
    .pair_reject(pair_reject));

  int checks = 0;
  int fails = 0;
  string cur_req = "R3";

  // Reference model state: [view][0=skip,1=last_px,2=last_ln,3=group]
  int stg [2][4];
  int act [2][4];
  int m_col = 0, m_line = 0;
  bit e_valid [2], e_sol [2], e_eol [2];
  logic [DW-1:0] e_data [2];
  bit e_reject = 0;

  int cnt [2];
  bit tally = 0;
  int hits [1:3840];

  task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, a, e);
    end
  endtask

  task automatic model_update();
    int eff [2][4];
    if (pix_valid && pix_sof) act = stg;
    eff = act;
    if (pix_valid) begin
      if (pix_sof) begin m_line = 1; m_col = 1; end
      else if (pix_sol) begin m_line++; m_col = 1; end
      else m_col++;
    end
    for (int k = 0; k < 2; k++) begin
      bit acc;
      acc = pix_valid && (eff[0][3] == eff[1][3]) && (m_col > eff[k][1-1])
            && (m_col <= eff[k][1]) && (m_line >= 1) && (m_line <= eff[k][2]);
      e_valid[k] = acc;
      e_sol[k] = acc && (m_col == eff[k][0] + 1);
      e_eol[k] = acc && (m_col == eff[k][1]);
      if (acc) e_data[k] = pix_data;
    end
    e_reject = (act[0][3] != act[1][3]);
    if (cfg_wr) begin
      int v;
      v = cfg_addr[3];
      case (cfg_addr[2:0])
        3'd0: stg[v][0] = (stg[v][0] & 32'hFF00) | cfg_wdata;
        3'd1: stg[v][0] = (stg[v][0] & 32'h00FF) | (int'(cfg_wdata) << 8);
        3'd2: stg[v][1] = (stg[v][1] & 32'hFF00) | cfg_wdata;
        3'd3: stg[v][1] = (stg[v][1] & 32'h00FF) | (int'(cfg_wdata) << 8);
        3'd4: stg[v][2] = (stg[v][2] & 32'hFF00) | cfg_wdata;
        3'd5: stg[v][2] = (stg[v][2] & 32'h00FF) | (int'(cfg_wdata) << 8);
        3'd6: stg[v][3] = cfg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    bit av [2], as [2], ae [2];
    logic [DW-1:0] ad [2];
    bit ok;
    av[0] = v0_valid; as[0] = v0_sol; ae[0] = v0_eol; ad[0] = v0_data;
    av[1] = v1_valid; as[1] = v1_sol; ae[1] = v1_eol; ad[1] = v1_data;
    for (int k = 0; k < 2; k++) begin
      ok = (av[k] == e_valid[k]);
      chk(ok, cur_req, $sformatf("view%0d valid col=%0d line=%0d", k, m_col, m_line), av[k], e_valid[k]);
      if (as[k] != e_sol[k])
        chk(0, "R5", $sformatf("view%0d sol col=%0d", k, m_col), as[k], e_sol[k]);
      if (ae[k] != e_eol[k])
        chk(0, "R6", $sformatf("view%0d eol col=%0d", k, m_col), ae[k], e_eol[k]);
      if (e_valid[k] && ad[k] !== e_data[k])
        chk(0, "R7", $sformatf("view%0d data", k), int'(ad[k]), int'(e_data[k]));
      if (av[k]) begin
        cnt[k]++;
        if (tally && ad[k][11:0] >= 1 && ad[k][11:0] <= 3840) hits[int'(ad[k][11:0])]++;
      end
    end
    if (pair_reject != e_reject)
      chk(0, "R9", "pair_reject", pair_reject, e_reject);
  endtask

  task automatic step(input bit v, input bit s, input bit f, input logic [DW-1:0] d,
                      input bit w, input logic [3:0] a, input logic [7:0] wd);
    pix_valid = v; pix_sol = s; pix_sof = f; pix_data = d;
    cfg_wr = w; cfg_addr = a; cfg_wdata = wd;
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    // junk markers and data while invalid must be ignored (R7)
    step(0, 1, 1, 24'hABCDEF, 0, 4'd0, 8'd0);
  endtask

  task automatic wr16(input int view, input int fld, input int val);
    step(0, 0, 0, '0, 1, {view[0], 3'(2*fld)}, val[7:0]);
    step(0, 0, 0, '0, 1, {view[0], 3'(2*fld+1)}, val[15:8]);
  endtask

  task automatic wrgrp(input int view, input int g);
    step(0, 0, 0, '0, 1, {view[0], 3'd6}, g[7:0]);
  endtask

  task automatic frame(input int width, input int lines, input bit gaps,
                       input int wr_line, input logic [3:0] wa, input logic [7:0] wd);
    cnt[0] = 0; cnt[1] = 0;
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < width; c++) begin
        bit w;
        w = (l == wr_line) && (c == width / 2);
        step(1, c == 0, (l == 0) && (c == 0), DW'(((l + 1) << 12) | (c + 1)), w, wa, wd);
        if (gaps && (c % 5 == 3)) idle();
      end
    end
    step(0, 0, 0, '0, 0, 4'd0, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++) for (int j = 0; j < 4; j++) begin stg[k][j] = 0; act[k][j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!v0_valid && !v1_valid && !v0_sol && !v0_eol && !v1_sol && !v1_eol,
        "R1", "outputs after reset", v0_valid | v1_valid, 0);
    chk(!pair_reject, "R1", "pair_reject after reset", pair_reject, 0);
    cur_req = "R1";
    frame(8, 2, 0, -1, 4'd0, 8'd0);
    chk(cnt[0] == 0 && cnt[1] == 0, "R1", "unconfigured emits nothing", cnt[0] + cnt[1], 0);

    // Small windows: view0 cols 3..6, view1 cols 7..10, lines 1..3
    wr16(0, 0, 2); wr16(0, 1, 6); wr16(0, 2, 3); wrgrp(0, 5);
    wr16(1, 0, 6); wr16(1, 1, 10); wr16(1, 2, 3); wrgrp(1, 5);
    cur_req = "R2/R3/R4";
    frame(12, 5, 1, -1, 4'd0, 8'd0);
    chk(cnt[0] == 12, "R3", "view0 pixels in frame", cnt[0], 12);
    chk(cnt[1] == 12, "R4", "view1 pixels (lines above 3 dropped)", cnt[1], 12);

    // Mid-frame skip change on view0 (skip 2 -> 4): old frame keeps width 4
    cur_req = "R8";
    frame(12, 5, 0, 1, 4'd0, 8'd4);
    chk(cnt[0] == 12, "R8", "frame with mid-frame write uses old skip", cnt[0], 12);
    frame(12, 5, 0, -1, 4'd0, 8'd0);
    chk(cnt[0] == 6, "R8", "next frame uses new skip", cnt[0], 6);

    // Group mismatch
    wrgrp(1, 7);
    chk(!pair_reject, "R8", "staged group not yet active", pair_reject, 0);
    cur_req = "R9";
    frame(12, 4, 0, -1, 4'd0, 8'd0);
    chk(pair_reject, "R9", "pair_reject after mismatched frame", pair_reject, 1);
    chk(cnt[0] == 0 && cnt[1] == 0, "R9", "rejected pair silent", cnt[0] + cnt[1], 0);
    wrgrp(1, 5);
    frame(12, 4, 0, -1, 4'd0, 8'd0);
    chk(!pair_reject && cnt[1] == 12, "R9", "restored pair emits", cnt[1], 12);

    // Full-width symmetric split: 3840 wide, 2 lines in window, 3 driven
    wr16(0, 0, 0); wr16(0, 1, 1920); wr16(0, 2, 2);
    wr16(1, 0, 1920); wr16(1, 1, 3840); wr16(1, 2, 2);
    for (int c = 1; c <= 3840; c++) hits[c] = 0;
    cur_req = "R10";
    tally = 1;
    frame(3840, 3, 0, -1, 4'd0, 8'd0);
    tally = 0;
    begin
      int bad;
      bad = 0;
      for (int c = 1; c <= 3840; c++) if (hits[c] != 2) bad++;
      chk(bad == 0, "R10", "columns not covered exactly once per line", bad, 0);
    end
    chk(cnt[0] == 3840, "R10", "view0 pixel count", cnt[0], 3840);
    chk(cnt[1] == 3840, "R10", "view1 pixel count", cnt[1], 3840);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule